// File: doc/BRIEF.md
# Debug Module Selector

This block sits at the front of a serial debug port. While the TAP holds the debug instruction, it watches each data-register scan. A scan whose first bit is 1 is a selection frame. It names one of the attached sub-modules, which are a system-bus access unit and a processor-control unit. The block checks the frame's CRC and looks up the identifier. It then shifts back a short status word and a CRC that covers only that status word. A scan whose first bit is 0 is a command for whichever sub-module is already selected. The selector leaves such scans alone.

The selection is held in a register and drives one-hot enables to the sub-modules. It survives any number of later scans. A host that wants the module it already has therefore sends nothing. A bad CRC or an unknown identifier leaves the old selection untouched and reports a nonzero status. A TAP test-logic-reset drops the selection to "none".

Top module: `dbg_module_selector`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mod_en` becomes all zero and `tdo` is 0.
- R2: A complete selection frame with a correct CRC and a known identifier sets `mod_en` to the one-hot code of that module in the cycle after the `update_dr` cycle. Identifier 0 sets `mod_en[0]` (bus unit) and identifier 1 sets `mod_en[1]` (processor unit).
- R3: The frame is shifted in this order: a flag bit at position 0, the 4-bit identifier MSB first at positions 1..4, then 32 CRC bits MSB first at positions 5..36. The CRC covers positions 0..4. It starts at all ones, and for each bit it shifts left and XORs in 0x04C11DB7 when the data bit differs from the old bit 31.
- R4: If any received CRC bit mismatches, status bit 3 is set and `mod_en` keeps its previous value.
- R5: An identifier that names no module (2..15 by default) sets status bit 2 and leaves `mod_en` unchanged.
- R6: Once the 37 frame bits are in, `tdo` presents the 4-bit status MSB first at shift positions 37..40. It then presents 32 CRC bits MSB first at positions 41..72. That CRC covers the 4 status bits under the R3 rule. A fully valid frame returns status 0.
- R7: A scan whose flag bit is 0 leaves `mod_en` unchanged, and `tdo` stays 0 throughout it.
- R8: `mod_en` changes only on an `update_dr` that ends a complete, valid selection frame. An update after fewer than 37 shifted bits has no effect, and repeated frames for the same module keep it selected.
- R9: A pulse on `tap_reset` clears `mod_en` to all zero in the next cycle.
- R10: While `ir_debug` is low, capture, shift and update have no effect on `mod_en`, and `tdo` is 0.
- R11: At most one bit of `mod_en` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_reset | input | 1 | TAP is in test-logic-reset |
| ir_debug | input | 1 | Debug instruction is loaded |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR; one bit per clock |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial reply (status, then status CRC) |
| mod_en | output | 2 | One-hot sub-module enables; all zero = none |

## Verification
A wrong bit counter or CRC accumulator shows up at the ports within one scan. A valid frame would come back with a nonzero status, or the enables would fail to move on the next update. A fault in the reply CRC register shows up in the last 32 `tdo` bits of that same scan. A leak in the selection register, such as a commit on a bad frame, a command scan or a short scan, changes `mod_en` one cycle after `update_dr`. So every vector compares the enables, the status and the reply CRC right after each scan.

// File: rtl/dbgsel_pkg.sv
// Shared constants and the serial CRC step used by the receive and reply
// paths of the debug module selector. Assumes a 32-bit CRC, MSB-first.
package dbgsel_pkg;
    localparam int CRC_W        = 32;
    localparam int STAT_W       = 4;
    localparam int STAT_CRC_BIT = 3;   // received CRC mismatch
    localparam int STAT_ID_BIT  = 2;   // identifier names no module

    // One serial CRC step: shift left, fold in polynomial on disagreement.
    function automatic logic [CRC_W-1:0] crc_next(
        input logic [CRC_W-1:0] c,
        input logic             d,
        input logic [CRC_W-1:0] poly
    );
        logic [CRC_W-1:0] s;
        s = {c[CRC_W-2:0], 1'b0};
        if (d != c[CRC_W-1]) s = s ^ poly;
        return s;
    endfunction
endpackage

// File: rtl/dbgsel_rx.sv
// Frame receiver: counts shifted bits, captures the flag and identifier,
// runs the CRC over the header and compares the received CRC bit by bit.
// Assumes one tdi bit per clock while shift is high; counter saturates.
module dbgsel_rx
    import dbgsel_pkg::*;
#(
    parameter int               ID_W     = 4,
    parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7,
    parameter int               CNT_W    = 7,
    parameter int               FRAME_LEN = 37,
    parameter int               TOTAL_LEN = 73
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_reset,
    input  logic             ir_debug,
    input  logic             capture,
    input  logic             shift,
    input  logic             tdi,
    output logic [CNT_W-1:0] cnt,
    output logic             sel_flag,
    output logic [ID_W-1:0]  id,
    output logic             crc_bad
);
    localparam logic [CNT_W-1:0] CRC_START_C = CNT_W'(ID_W + 1);
    localparam logic [CNT_W-1:0] FRAME_C     = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] TOTAL_C     = CNT_W'(TOTAL_LEN);

    logic [CRC_W-1:0] crc_acc;

    // Advance the bit position and update flag, id, CRC and mismatch state.
    always_ff @(posedge clk) begin
        if (!rst_n || tap_reset) begin
            cnt      <= '0;
            sel_flag <= 1'b0;
            id       <= '0;
            crc_acc  <= '1;
            crc_bad  <= 1'b0;
        end else if (ir_debug && capture) begin
            cnt      <= '0;
            sel_flag <= 1'b0;
            id       <= '0;
            crc_acc  <= '1;
            crc_bad  <= 1'b0;
        end else if (ir_debug && shift && cnt < TOTAL_C) begin
            cnt <= cnt + 1'b1;
            if (cnt == '0) sel_flag <= tdi;
            if (cnt != '0 && cnt < CRC_START_C) id <= {id[ID_W-2:0], tdi};
            if (cnt < CRC_START_C) begin
                crc_acc <= crc_next(crc_acc, tdi, CRC_POLY);
            end else if (cnt < FRAME_C) begin
                crc_acc <= {crc_acc[CRC_W-2:0], 1'b0};
                if (tdi != crc_acc[CRC_W-1]) crc_bad <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbgsel_decode.sv
// Identifier lookup: compares the received id against each module's
// assigned code. Assumes the codes in MOD_IDS are distinct.
module dbgsel_decode #(
    parameter int                      ID_W    = 4,
    parameter int                      NUM_MOD = 2,
    parameter logic [NUM_MOD*ID_W-1:0] MOD_IDS = {4'd1, 4'd0}
) (
    input  logic [ID_W-1:0]    id,
    output logic [NUM_MOD-1:0] hit
);
    // One comparator per attached module.
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_cmp
        assign hit[i] = (id == MOD_IDS[i*ID_W +: ID_W]);
    end
endmodule

// File: rtl/dbgsel_selreg.sv
// Selection register: holds the one-hot enable vector between frames.
// Assumes commit is only raised with a one-hot hit vector.
module dbgsel_selreg #(
    parameter int NUM_MOD = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tap_reset,
    input  logic               commit,
    input  logic [NUM_MOD-1:0] hit,
    output logic [NUM_MOD-1:0] mod_en
);
    // Load a new selection on commit; clear on either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || tap_reset) mod_en <= '0;
        else if (commit)         mod_en <= hit;
    end
endmodule

// File: rtl/dbgsel_tx.sv
// Reply serializer: after the frame, drives the status word MSB first,
// then a CRC over those status bits, MSB first. Assumes the status input
// is stable once the bit position reaches FRAME_LEN.
module dbgsel_tx
    import dbgsel_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_POLY  = 32'h04C1_1DB7,
    parameter int               CNT_W     = 7,
    parameter int               FRAME_LEN = 37,
    parameter int               TOTAL_LEN = 73
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tap_reset,
    input  logic              ir_debug,
    input  logic              capture,
    input  logic              shift,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              active,
    input  logic [STAT_W-1:0] status,
    output logic              tdo
);
    localparam logic [CNT_W-1:0] CRC_OUT_C = CNT_W'(FRAME_LEN + STAT_W);
    localparam logic [CNT_W-1:0] TOTAL_C   = CNT_W'(TOTAL_LEN);

    logic             in_stat;
    logic             in_crc;
    logic             stat_bit;
    logic [CRC_W-1:0] crc_out;

    // Select the status bit that belongs to the current position.
    always_comb begin
        in_stat  = 1'b0;
        stat_bit = 1'b0;
        for (int i = 0; i < STAT_W; i++) begin
            if (cnt == CNT_W'(FRAME_LEN + i)) begin
                in_stat  = 1'b1;
                stat_bit = status[STAT_W-1-i];
            end
        end
        in_crc = (cnt >= CRC_OUT_C) && (cnt < TOTAL_C);
    end

    // Accumulate the reply CRC over status bits, then shift it out.
    always_ff @(posedge clk) begin
        if (!rst_n || tap_reset) begin
            crc_out <= '1;
        end else if (ir_debug && capture) begin
            crc_out <= '1;
        end else if (ir_debug && shift) begin
            if (in_stat)     crc_out <= crc_next(crc_out, stat_bit, CRC_POLY);
            else if (in_crc) crc_out <= {crc_out[CRC_W-2:0], 1'b0};
        end
    end

    // Reply only during selection frames and only under the debug instruction.
    always_comb begin
        tdo = 1'b0;
        if (ir_debug && active) begin
            if (in_stat)     tdo = stat_bit;
            else if (in_crc) tdo = crc_out[CRC_W-1];
        end
    end
endmodule

// File: rtl/dbg_module_selector.sv
// Top of the debug module selector. Receives selection frames under the
// debug instruction, validates CRC and identifier, commits the one-hot
// module enable on Update-DR and serializes a status reply. Assumes the
// TAP controller supplies its state decodes synchronous to clk.
module dbg_module_selector
    import dbgsel_pkg::*;
#(
    parameter int                      ID_W     = 4,
    parameter int                      NUM_MOD  = 2,
    parameter logic [NUM_MOD*ID_W-1:0] MOD_IDS  = {4'd1, 4'd0},
    parameter logic [CRC_W-1:0]        CRC_POLY = 32'h04C1_1DB7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tap_reset,
    input  logic               ir_debug,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    output logic               tdo,
    output logic [NUM_MOD-1:0] mod_en
);
    localparam int FRAME_LEN = 1 + ID_W + CRC_W;
    localparam int TOTAL_LEN = FRAME_LEN + STAT_W + CRC_W;
    localparam int CNT_W     = $clog2(TOTAL_LEN + 1);
    localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_LEN);

    logic [CNT_W-1:0]   cnt;
    logic               sel_flag;
    logic [ID_W-1:0]    id;
    logic               crc_bad;
    logic [NUM_MOD-1:0] hit;
    logic [STAT_W-1:0]  status;
    logic               commit;

    dbgsel_rx #(
        .ID_W(ID_W), .CRC_POLY(CRC_POLY), .CNT_W(CNT_W),
        .FRAME_LEN(FRAME_LEN), .TOTAL_LEN(TOTAL_LEN)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .ir_debug(ir_debug),
        .capture(capture_dr), .shift(shift_dr), .tdi(tdi),
        .cnt(cnt), .sel_flag(sel_flag), .id(id), .crc_bad(crc_bad)
    );

    dbgsel_decode #(
        .ID_W(ID_W), .NUM_MOD(NUM_MOD), .MOD_IDS(MOD_IDS)
    ) u_dec (
        .id(id), .hit(hit)
    );

    // Form the status word from the two failure causes.
    always_comb begin
        status               = '0;
        status[STAT_CRC_BIT] = crc_bad;
        status[STAT_ID_BIT]  = ~|hit;
    end

    // Commit only a complete, clean selection frame at Update-DR.
    assign commit = ir_debug && update_dr && sel_flag &&
                    (cnt >= FRAME_C) && (status == '0);

    dbgsel_selreg #(.NUM_MOD(NUM_MOD)) u_sel (
        .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset),
        .commit(commit), .hit(hit), .mod_en(mod_en)
    );

    dbgsel_tx #(
        .CRC_POLY(CRC_POLY), .CNT_W(CNT_W),
        .FRAME_LEN(FRAME_LEN), .TOTAL_LEN(TOTAL_LEN)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .ir_debug(ir_debug),
        .capture(capture_dr), .shift(shift_dr), .cnt(cnt),
        .active(sel_flag), .status(status), .tdo(tdo)
    );
endmodule

// File: rtl/dbgsel_chk.sv
// Port-level checker for the debug module selector, bound to the top.
module dbgsel_chk #(
    parameter int NUM_MOD = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tap_reset,
    input logic               ir_debug,
    input logic               capture_dr,
    input logic               update_dr,
    input logic               tdo,
    input logic [NUM_MOD-1:0] mod_en
);
    // R11
    enable_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_en));

    // R9
    tap_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_reset |=> (mod_en == '0));

    // R8
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_dr && !tap_reset) |=> $stable(mod_en));

    // R10
    ir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ir_debug && !tap_reset) |=> $stable(mod_en));

    // R10
    ir_quiet_tdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_debug |-> !tdo);

    // R6
    capture_quiet_tdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_debug && capture_dr && !tap_reset) |=> !tdo);
endmodule

bind dbg_module_selector dbgsel_chk #(.NUM_MOD(NUM_MOD)) u_chk (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .ir_debug(ir_debug),
    .capture_dr(capture_dr), .update_dr(update_dr), .tdo(tdo), .mod_en(mod_en)
);

// File: tb/sim_dbg_module_selector.sv
module sim_dbg_module_selector;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] POLY       = 32'h04C1_1DB7;
    localparam int          NVEC       = 10;
    // {id[3:0], corrupt, expected mod_en[1:0]}
    localparam logic [6:0] VEC [NVEC] = '{
        {4'd1,  1'b0, 2'b10},
        {4'd0,  1'b0, 2'b01},
        {4'd1,  1'b1, 2'b01},
        {4'd5,  1'b0, 2'b01},
        {4'd15, 1'b1, 2'b01},
        {4'd1,  1'b0, 2'b10},
        {4'd1,  1'b0, 2'b10},   // R8 reselect same module
        {4'd2,  1'b0, 2'b10},
        {4'd0,  1'b0, 2'b01},
        {4'd0,  1'b1, 2'b01}
    };

    logic       clk = 1'b0;
    logic       rst_n, tap_reset, ir_debug, capture_dr, shift_dr, update_dr, tdi;
    logic       tdo;
    logic [1:0] mod_en;
    int         checks = 0;
    int         fails  = 0;

    dbg_module_selector u0 (
        .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .ir_debug(ir_debug),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .mod_en(mod_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] step(input logic [31:0] c, input logic d);
        logic [31:0] s;
        s = {c[30:0], 1'b0};
        if (d != c[31]) s = s ^ POLY;
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic flg, input logic [3:0] idv, input logic bad,
                              input int nbits, output logic [3:0] st,
                              output logic [31:0] rc, output logic any);
        logic [36:0] f;
        logic [72:0] rep;
        logic [31:0] c;
        f = '0; rep = '0; any = 1'b0;
        f[0] = flg;
        for (int i = 0; i < 4; i++) f[1+i] = idv[3-i];
        c = '1;
        for (int i = 0; i < 5; i++) c = step(c, f[i]);
        for (int i = 0; i < 32; i++) f[5+i] = c[31-i];
        if (bad) f[5] = ~f[5];
        @(negedge clk) capture_dr = 1'b1;
        @(negedge clk) capture_dr = 1'b0;
        for (int p = 0; p < nbits; p++) begin
            if (p > 0) @(negedge clk);
            shift_dr = 1'b1;
            tdi = (p < 37) ? f[p] : 1'b0;
            #1;
            rep[p] = tdo;
            any = any | tdo;
        end
        @(negedge clk) begin shift_dr = 1'b0; update_dr = 1'b1; end
        @(negedge clk) update_dr = 1'b0;
        #1;
        for (int i = 0; i < 4; i++)  st[3-i] = rep[37+i];
        for (int i = 0; i < 32; i++) rc[31-i] = rep[41+i];
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0]  st;
        logic [31:0] rc;
        logic        any;
        rst_n = 1'b0; tap_reset = 1'b0; ir_debug = 1'b1;
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 enables after reset", 32'(mod_en), 32'h0);
        chk("R1 tdo after reset", 32'(tdo), 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            logic [3:0]  vid;
            logic        vbad;
            logic [1:0]  ven;
            logic [3:0]  est;
            logic [31:0] ec;
            {vid, vbad, ven} = VEC[v];
            est = {vbad, (vid > 4'd1), 2'b00};
            ec = '1;
            for (int i = 3; i >= 0; i--) ec = step(ec, est[i]);
            send_frame(1'b1, vid, vbad, 73, st, rc, any);
            chk(vbad ? "R4 enables" : (vid > 4'd1) ? "R5 enables" : "R2 R3 enables",
                32'(mod_en), 32'(ven));
            chk("R6 status", 32'(st), 32'(est));
            chk("R6 reply crc", rc, ec);
            chk("R11 one-hot", 32'($countones(mod_en) <= 1), 32'h1);
        end

        // R7: command scan (flag 0) for another module
        send_frame(1'b0, 4'd1, 1'b0, 73, st, rc, any);
        chk("R7 enables after command scan", 32'(mod_en), 32'h1);
        chk("R7 tdo quiet", 32'(any), 32'h0);

        // R8: truncated selection frame
        send_frame(1'b1, 4'd1, 1'b0, 20, st, rc, any);
        chk("R8 short frame", 32'(mod_en), 32'h1);

        // R10: debug instruction not loaded
        ir_debug = 1'b0;
        send_frame(1'b1, 4'd1, 1'b0, 73, st, rc, any);
        chk("R10 enables", 32'(mod_en), 32'h1);
        chk("R10 tdo", 32'(any), 32'h0);
        ir_debug = 1'b1;

        // R9: TAP reset clears selection
        send_frame(1'b1, 4'd1, 1'b0, 73, st, rc, any);
        chk("R2 select processor", 32'(mod_en), 32'h2);
        @(negedge clk) tap_reset = 1'b1;
        @(negedge clk) tap_reset = 1'b0;
        #1;
        chk("R9 cleared", 32'(mod_en), 32'h0);

        // R4: bad frame from the empty state
        send_frame(1'b1, 4'd0, 1'b1, 73, st, rc, any);
        chk("R4 stays none", 32'(mod_en), 32'h0);
        chk("R4 status", 32'(st), 32'h8);

        // R1: reset with a live selection
        send_frame(1'b1, 4'd0, 1'b0, 73, st, rc, any);
        chk("R2 select bus", 32'(mod_en), 32'h1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 reset clears selection", 32'(mod_en), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule